// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access a core issues, whether that access may proceed. It holds no registers of its own for configuration: it reads eight region descriptors, an instruction-side and a data-side permission word, and a global protection switch from the surrounding control logic. For each request it reports an allow or deny verdict, the kind of fault, and the read and write rights that the winning region grants to the requesting privilege level.

All eight regions are compared against the address in parallel. Where regions overlap, the highest-numbered enabled region that matches decides. A missing match is a background fault, which is reported apart from a permission fault. The verdict is computed combinationally and registered, so a response appears with a valid strobe exactly one clock after the request. The address is returned unchanged because no translation takes place.

Top module: `mpu_region_check`

## Requirements
- R1: When `prot_on` is 0, every request is allowed with `rsp_rd`=1, `rsp_wr`=1 and `rsp_fault`=0 (none), whatever the region settings.
- R2: Each 32-bit region descriptor uses bit 0 as its enable and bits [5:1] as a size value N, so the region spans 2^(N+1) bytes. A region whose enable bit is 0 never matches.
- R3: An enabled region matches when the address equals the descriptor in every bit above position N. With N=31 the region matches every address.
- R4: When several enabled regions match, the one with the highest index decides the outcome.
- R5: When no enabled region matches and `prot_on` is 1, the response is denied with `rsp_fault`=1 (background) and `rsp_rd`=`rsp_wr`=0.
- R6: `req_kind` encodes 0 as fetch, 1 as data read and 2 as data write. A fetch takes its code from `perm_insn` and data accesses take theirs from `perm_data`. The code for region n sits in bits [4n+3:4n].
- R7: Permission codes give these rights, written privileged/user: code 0 none/none; code 1 rw/none; code 2 rw/read; code 3 rw/rw; code 5 read/none; code 6 read/read.
- R8: Any code other than 0, 1, 2, 3, 5 or 6 grants no rights and the access is denied with `rsp_fault`=2 (permission).
- R9: A fetch or a read needs the read right and a write needs the write right. If the right is missing, the access is denied with `rsp_fault`=2, and `rsp_rd`/`rsp_wr` still report the rights that were granted.
- R10: A response (`rsp_valid`=1) appears on the cycle after a cycle with `req_valid`=1, and `rsp_valid` is 0 otherwise. `rsp_addr` carries the request address unchanged.
- R11: While `rst` is 1, and on the cycle after it is released, `rsp_valid`, `rsp_allow`, `rsp_rd`, `rsp_wr` and `rsp_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write |
| req_priv | input | 1 | 1 for a privileged access, 0 for a user access |
| prot_on | input | 1 | Global protection enable |
| region_cfg | input | 256 | Eight descriptors; region n occupies bits [32n+31:32n] |
| perm_insn | input | 32 | Fetch permission codes, 4 bits per region |
| perm_data | input | 32 | Data permission codes, 4 bits per region |
| rsp_valid | output | 1 | Response strobe |
| rsp_allow | output | 1 | Access allowed |
| rsp_fault | output | 2 | 0 none, 1 background, 2 permission |
| rsp_rd | output | 1 | Read right granted |
| rsp_wr | output | 1 | Write right granted |
| rsp_addr | output | 32 | Request address passed through |

## Verification
On every cycle the assertions check the response timing and the address pass-through. They also check that the verdict agrees with the fault code, that a background fault never carries rights, that write rights never come without read rights, that an allowed write always has the write right, and that the switched-off mode grants everything. Only the bench scenarios can show which region wins an overlap and how the size mask behaves at its edges, including N=31. They also show that each permission code maps to the correct rights for both privilege levels, that fetches and data accesses pick the correct permission word, and that a disabled region is skipped.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int ADDR_W      = 32;
    localparam int NUM_REGIONS = 8;
    localparam int SIZE_W      = 5;
    localparam int CODE_W      = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_BG   = 2'd1,
        FLT_PERM = 2'd2
    } fault_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } rights_t;

    typedef struct packed {
        logic    code_ok;
        rights_t rights;
    } perm_t;

    // Map a permission code and privilege level to granted rights.
    function automatic perm_t decode_perm(input logic [CODE_W-1:0] code, input logic priv);
        perm_t p;
        p = '{code_ok: 1'b1, rights: '{rd: 1'b0, wr: 1'b0}};
        case (code)
            4'd0: p.rights = '{rd: 1'b0, wr: 1'b0};
            4'd1: p.rights = '{rd: priv, wr: priv};
            4'd2: p.rights = '{rd: 1'b1, wr: priv};
            4'd3: p.rights = '{rd: 1'b1, wr: 1'b1};
            4'd5: p.rights = '{rd: priv, wr: 1'b0};
            4'd6: p.rights = '{rd: 1'b1, wr: 1'b0};
            default: p.code_ok = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SIZE_W
) (
    input  logic [AW-1:0] cfg,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [SW-1:0] size_n;
    logic [AW-1:0] low_mask;

    assign size_n = cfg[SW:1];

    // Bit i belongs to the offset field when i <= N; N = max gives all ones.
    for (genvar i = 0; i < AW; i++) begin : g_mask
        assign low_mask[i] = (32'(i) <= 32'(size_n));
    end

    assign hit = cfg[0] && (((cfg ^ addr) & ~low_mask) == '0);

endmodule

// File: rtl/prot_prio_select.sv
module prot_prio_select #(
    parameter int N     = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hits,
    output logic          any_hit,
    output logic [IW-1:0] win_idx
);
    // Ascending scan; a later (higher) hit overwrites, so the top index wins.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/prot_perm_decode.sv
module prot_perm_decode
    import prot_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              priv,
    input  acc_kind_e         kind,
    output rights_t           rights,
    output logic              permitted
);
    perm_t p;
    logic  need_wr;

    assign p         = decode_perm(code, priv);
    assign rights    = p.rights;
    assign need_wr   = (kind == ACC_WRITE);
    assign permitted = p.code_ok && (need_wr ? p.rights.wr : p.rights.rd);

endmodule

// File: rtl/mpu_region_check.sv
module mpu_region_check
    import prot_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int NREG    = NUM_REGIONS,
    parameter int SW      = SIZE_W,
    localparam int IW     = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int CFG_W  = NREG * AW,
    localparam int PERM_W = NREG * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic              prot_on,
    input  logic [CFG_W-1:0]  region_cfg,
    input  logic [PERM_W-1:0] perm_insn,
    input  logic [PERM_W-1:0] perm_data,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [1:0]        rsp_fault,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic [AW-1:0]     rsp_addr
);
    acc_kind_e         kind;
    logic [NREG-1:0]   hits;
    logic              any_hit;
    logic [IW-1:0]     win_idx;
    logic [PERM_W-1:0] perm_sel;
    logic [CODE_W-1:0] win_code;
    rights_t           win_rights;
    logic              win_ok;

    logic              nx_allow;
    fault_e            nx_fault;
    rights_t           nx_rights;
    acc_kind_e         kind_q;

    assign kind = (req_kind == 2'd2) ? ACC_WRITE :
                  (req_kind == 2'd0) ? ACC_FETCH : ACC_READ;

    for (genvar r = 0; r < NREG; r++) begin : g_region
        prot_region_match #(.AW(AW), .SW(SW)) u_match (
            .cfg  (region_cfg[r*AW +: AW]),
            .addr (req_addr),
            .hit  (hits[r])
        );
    end

    prot_prio_select #(.N(NREG)) u_prio (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    assign perm_sel = (kind == ACC_FETCH) ? perm_insn : perm_data;
    assign win_code = perm_sel[int'(win_idx)*CODE_W +: CODE_W];

    prot_perm_decode u_perm (
        .code      (win_code),
        .priv      (req_priv),
        .kind      (kind),
        .rights    (win_rights),
        .permitted (win_ok)
    );

    always_comb begin
        if (!prot_on) begin
            nx_allow  = 1'b1;
            nx_fault  = FLT_NONE;
            nx_rights = '{rd: 1'b1, wr: 1'b1};
        end else if (!any_hit) begin
            nx_allow  = 1'b0;
            nx_fault  = FLT_BG;
            nx_rights = '{rd: 1'b0, wr: 1'b0};
        end else begin
            nx_allow  = win_ok;
            nx_fault  = win_ok ? FLT_NONE : FLT_PERM;
            nx_rights = win_rights;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_addr  <= '0;
            kind_q    <= ACC_READ;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_allow <= nx_allow;
                rsp_fault <= nx_fault;
                rsp_rd    <= nx_rights.rd;
                rsp_wr    <= nx_rights.wr;
                rsp_addr  <= req_addr;
                kind_q    <= kind;
            end
        end
    end

    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10
    rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R10
    addr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_addr == $past(req_addr)));

    // R9
    verdict_matches_fault_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_allow == (rsp_fault == FLT_NONE)));

    // R5
    bg_no_rights_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == FLT_BG) |-> (!rsp_rd && !rsp_wr));

    // R7
    wr_implies_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (!rsp_wr || rsp_rd));

    // R9
    allowed_write_has_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_allow && kind_q == ACC_WRITE) |-> rsp_wr);

    // R1
    prot_off_grants_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !prot_on) |=> (rsp_allow && rsp_rd && rsp_wr && rsp_fault == FLT_NONE));

endmodule

// File: tb/sim_mpu_region_check.sv
module sim_mpu_region_check;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic [1:0]   req_kind;
    logic         req_priv;
    logic         prot_on;
    logic [255:0] region_cfg;
    logic [31:0]  perm_insn;
    logic [31:0]  perm_data;
    logic         rsp_valid;
    logic         rsp_allow;
    logic [1:0]   rsp_fault;
    logic         rsp_rd;
    logic         rsp_wr;
    logic [31:0]  rsp_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    mpu_region_check u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_priv(req_priv), .prot_on(prot_on),
        .region_cfg(region_cfg), .perm_insn(perm_insn), .perm_data(perm_data),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_addr(rsp_addr)
    );

    // {addr, kind, priv, allow, fault, rd, wr}; kind 0 fetch, 1 read, 2 write
    localparam int NV = 18;
    localparam logic [39:0] VEC [NV] = '{
        {32'h0000_1000, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R7 code 6 user read
        {32'h0000_1000, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0}, // R9 write to read-only
        {32'h0000_1000, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1}, // R6 fetch uses insn code 3
        {32'h1000_2000, 2'd2, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1}, // R7 code 1 privileged
        {32'h1000_2000, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}, // R7 code 1 user
        {32'h1000_0800, 2'd1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0}, // R4 region 5 over 1
        {32'h1000_0800, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0}, // R4 code 5 no write
        {32'h1000_0800, 2'd1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0}, // R7 code 5 user
        {32'h1000_0800, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R6 insn code 6
        {32'h2000_0FFF, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0}, // R7 code 2 user write
        {32'h2000_0FFF, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 top byte of region
        {32'h2000_0004, 2'd2, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1}, // R7 code 2 privileged
        {32'h2000_1000, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 just past region 2
        {32'h2000_0010, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0}, // R6 insn code 5 priv
        {32'h3000_0000, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0}, // R2 disabled region 3
        {32'h4000_00FF, 2'd1, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}, // R8 code 7
        {32'h4000_0100, 2'd1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0}, // R3 past region 7
        {32'h4000_0000, 2'd0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0}  // R8 insn code 4
    };

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic p);
        req_addr  = a;
        req_kind  = k;
        req_priv  = p;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [39:0] resp();
        return {34'd0, rsp_valid, rsp_allow, rsp_fault, rsp_rd, rsp_wr};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        req_valid  = 1'b1;
        req_addr   = 32'h0;
        req_kind   = 2'd1;
        req_priv   = 1'b1;
        prot_on    = 1'b0;
        region_cfg = '0;
        region_cfg[0*32 +: 32] = 32'h0000_003F; // whole space, N=31
        region_cfg[1*32 +: 32] = 32'h1000_001F; // 64 KB
        region_cfg[2*32 +: 32] = 32'h2000_0017; // 4 KB
        region_cfg[3*32 +: 32] = 32'h3000_0016; // disabled
        region_cfg[5*32 +: 32] = 32'h1000_0017; // 4 KB inside region 1
        region_cfg[7*32 +: 32] = 32'h4000_000F; // 256 B
        perm_data  = 32'h7050_3216;
        perm_insn  = 32'h4060_3503;

        repeat (3) @(negedge clk);
        // R11 reset state while requests are presented
        check("R11", resp(), 40'd0);
        rst = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check("R11", resp(), 40'd0);

        // R1 protection switched off: everything granted
        issue(32'h4000_00FF, 2'd2, 1'b0);
        check("R1", resp(), {34'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1});
        check("R10", {8'd0, rsp_addr}, {8'd0, 32'h4000_00FF});

        // R10 no request, no response
        @(negedge clk);
        check("R10", {39'd0, rsp_valid}, 40'd0);

        prot_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][39:8], VEC[i][7:6], VEC[i][5]);
            check("R2-R9 vector", resp(), {34'd0, 1'b1, VEC[i][4:0]});
            check("R10", {8'd0, rsp_addr}, {8'd0, VEC[i][39:8]});
        end

        // R5 background fault once the catch-all region is disabled
        region_cfg[0*32 +: 32] = 32'h0000_003E;
        issue(32'h5000_0000, 2'd1, 1'b1);
        check("R5", resp(), {34'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0});
        issue(32'h0000_1000, 2'd0, 1'b1);
        check("R5", resp(), {34'd0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0});

        // R3 N=31 with all-ones base bits still covers every address
        region_cfg[0*32 +: 32] = 32'hFFFF_FFFF;
        issue(32'h5000_0000, 2'd1, 1'b0);
        check("R3", resp(), {34'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0});

        // R4 region 5 wins over region 1; region 1 still serves outside region 5
        issue(32'h1000_1000, 2'd1, 1'b0);
        check("R4", resp(), {34'd0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0});

        // R6 region 7 data nibble changed to 3 alters data only, fetch still faults
        perm_data[31:28] = 4'd3;
        issue(32'h4000_0010, 2'd2, 1'b0);
        check("R6", resp(), {34'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1});
        issue(32'h4000_0010, 2'd0, 1'b0);
        check("R8", resp(), {34'd0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0});

        // R2 enabling region 3 makes its code 3 take effect
        region_cfg[3*32 +: 32] = 32'h3000_0017;
        issue(32'h3000_0000, 2'd2, 1'b0);
        check("R2", resp(), {34'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1});

        // R11 reset mid-run clears the response
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11", resp(), 40'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule